// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the serial front end of a small nonvolatile byte store of 2^ADDR_W bytes (512 by default), with the array held in on-chip registers. A host drives chip select (`cs_n`, active low), the serial clock and serial data in. The block returns data on `so_data` together with an output enable `so_oe` for an external tri-state pad. All serial inputs are brought into the system clock domain through a synchroniser. Bits are taken on rising serial-clock edges and presented on falling edges, so both idle-low (mode 0) and idle-high (mode 3) hosts work without configuration.

Four commands are decoded: sequential read, status read, write-enable and single-byte write. A byte write is accepted only when three conditions hold: the write-enable latch was set by an earlier, separately closed enable frame; the frame held exactly 24 bits; and the target lies outside the range picked by the `prot_level` input. When a write is accepted, a timed internal write cycle of WR_CYCLES system clocks begins. During that cycle only the status read is serviced. At the end of the cycle the write-enable latch drops.

The frame state machine has the states F_IDLE, F_OPCODE, F_ADDR, F_WR_DATA, F_WR_END, F_WREN_END, F_RD_DATA, F_SR_DATA and F_DISCARD. Every state returns to F_IDLE when chip select goes high, and F_IDLE moves to F_OPCODE once chip select is low. When eight opcode bits have arrived, F_OPCODE moves to F_SR_DATA, F_WREN_END or F_ADDR, or moves to F_DISCARD if the opcode is unknown or a write cycle is running. After eight address bits, F_ADDR moves to F_RD_DATA for a read or F_WR_DATA for a write. After eight data bits, F_WR_DATA moves to F_WR_END. Any further rising edge moves F_WR_END or F_WREN_END to F_DISCARD. The write engine has two states: W_IDLE moves to W_BUSY when an accepted write starts, and W_BUSY returns to W_IDLE when its timer expires.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset `so_oe` is 0, every byte of the array reads 0x00, and both the write-enable latch and the write-in-progress flag are 0.
- R2: A read frame sends opcode 0000A011 (A = address bit 8), then address bits 7..0, all MSB first. The byte at that address is then driven bit 7 first, in both mode 0 and mode 3.
- R3: A read continues on further clocks with the next address, and wraps from the highest address to 0 without limit.
- R4: Opcode 00000101 returns the status byte {0000, prot_level[1:0], WEL, WIP}, repeated for as long as clocks continue. It is serviced while a write cycle runs, and WIP reads 1 during that cycle.
- R5: Opcode 00000110 sets WEL only when chip select rises after exactly 8 bits of that frame.
- R6: A write frame of opcode 0000A010, address and one data byte, closed after exactly 24 bits while WEL is 1 and the address is unprotected, stores the byte and holds WIP at 1 for WR_CYCLES clocks.
- R7: A write is not performed while WEL is 0, including a write sent in the same frame as the enable.
- R8: A write frame closed after any bit count other than 24 stores nothing and starts no write cycle.
- R9: prot_level 00 protects nothing, 01 protects the upper quarter, 10 the upper half and 11 the whole array. A write into a protected address is discarded, starts no cycle and leaves WEL unchanged.
- R10: While WIP is 1, every command except the status read is ignored: a read never enables `so_oe` and a write stores nothing.
- R11: `so_oe` is 1 only while read or status data is being shifted out. It is 0 during opcode and address bits and after chip select rises.
- R12: At the end of a write cycle, WIP and WEL clear in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| prot_level | input | 2 | Block-protect level, reported in status bits 3:2 |
| so_data | output | 1 | Serial data to the host |
| so_oe | output | 1 | Enable for the external tri-state driver of `so_data` |

## Verification
The end of the internal write cycle, which drops WIP and WEL, can land in the same clock as the capture of a status byte that is about to be shifted out. To provoke this, the bench issues a status read right after each accepted write and keeps clocking status bytes until WIP reads 0. It judges that the first byte shows WIP and WEL both set, and that no byte ever shows WIP clear while WEL is still set. A second overlap, a read or a write arriving while the cycle runs, is judged by `so_oe` staying low and by the target byte being unchanged once the cycle ends.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_ENABLE = 8'h06;
    localparam logic [2:0] OPC_RD_LOW = 3'b011;
    localparam logic [2:0] OPC_WR_LOW = 3'b010;

    typedef enum logic [3:0] {
        F_IDLE,
        F_OPCODE,
        F_ADDR,
        F_WR_DATA,
        F_WR_END,
        F_WREN_END,
        F_RD_DATA,
        F_SR_DATA,
        F_DISCARD
    } frame_state_t;

    typedef enum logic {
        W_IDLE,
        W_BUSY
    } wr_state_t;

    // Protection decision from the level and the two top address bits
    function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top);
        logic hit;
        unique case (lvl)
            2'd0: hit = 1'b0;
            2'd1: hit = (top == 2'b11);
            2'd2: hit = top[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_act,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] mo_p;
    logic              cs_d;
    logic              sck_d;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_p  <= '1;
                    sck_p <= '0;
                    mo_p  <= '0;
                end else begin
                    cs_p  <= {cs_p[LAST-1:0], cs_n};
                    sck_p <= {sck_p[LAST-1:0], sck};
                    mo_p  <= {mo_p[LAST-1:0], mosi};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_p  <= '1;
                    sck_p <= '0;
                    mo_p  <= '0;
                end else begin
                    cs_p  <= cs_n;
                    sck_p <= sck;
                    mo_p  <= mosi;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_p[LAST];
            sck_d <= sck_p[LAST];
        end
    end

    assign cs_act   = !cs_p[LAST];
    assign cs_rise  = cs_p[LAST] && !cs_d;
    assign sck_rise = sck_p[LAST] && !sck_d;
    assign sck_fall = !sck_p[LAST] && sck_d;
    assign mosi_s   = mo_p[LAST];

endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int WR_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        prot_level,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              wel
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TW    = $clog2(WR_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(WR_CYCLES - 1);

    logic [7:0]  mem [DEPTH];
    wr_state_t   wstate, wnext;
    logic [TW-1:0] tmr;
    logic        start;
    logic        done;

    assign start = wr_req && wel && (wstate == W_IDLE)
                   && !prot_hit(prot_level, wr_addr[ADDR_W-1:ADDR_W-2]);
    assign done  = (wstate == W_BUSY) && (tmr == T_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wstate <= W_IDLE;
        else        wstate <= wnext;
    end

    always_comb begin
        wnext = wstate;
        unique case (wstate)
            W_IDLE: if (start) wnext = W_BUSY;
            W_BUSY: if (done)  wnext = W_IDLE;
            default: wnext = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
            wel <= 1'b0;
        end else begin
            tmr <= (wstate == W_BUSY && !done) ? tmr + 1'b1 : '0;
            if (done)          wel <= 1'b0;
            else if (wren_req) wel <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (start) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = (wstate == W_BUSY);

    AST_WEL_DROPS_WITH_WIP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R12
    AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R7
    AST_WEL_ONLY_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(wren_req)); // R5
    AST_FULL_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(prot_level) != 2'd3)); // R9

endmodule

// File: rtl/eep_frame.sv
module eep_frame
    import eep_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              busy,
    input  logic              wel,
    input  logic [1:0]        prot_level,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              wren_req,
    output logic              wr_req,
    output logic [7:0]        wr_data,
    output logic              so_data,
    output logic              so_oe
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    frame_state_t state, nxt;
    logic [7:0]   shreg;
    logic [7:0]   byte_in;
    logic [2:0]   cnt;
    logic         is_read;
    logic         a8;
    logic [8:0]   full_addr;
    logic [7:0]   obuf;
    logic [7:0]   status;
    logic [7:0]   fresh;
    logic         last_bit;

    assign byte_in   = {shreg[6:0], mosi_s};
    assign full_addr = {a8, byte_in};
    assign last_bit  = sck_rise && (cnt == 3'd7);
    assign status    = {4'b0000, prot_level, wel, busy};
    assign fresh     = (state == F_RD_DATA) ? rd_data : status;

    function automatic frame_state_t decode(input logic [7:0] op, input logic wip);
        frame_state_t d;
        if (op == OPC_STATUS)                           d = F_SR_DATA;
        else if (wip)                                   d = F_DISCARD;
        else if (op == OPC_ENABLE)                      d = F_WREN_END;
        else if (op[7:4] == 4'b0 && op[2:0] == OPC_RD_LOW) d = F_ADDR;
        else if (op[7:4] == 4'b0 && op[2:0] == OPC_WR_LOW) d = F_ADDR;
        else                                            d = F_DISCARD;
        return d;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!cs_act) begin
            nxt = F_IDLE;
        end else begin
            unique case (state)
                F_IDLE:     nxt = F_OPCODE;
                F_OPCODE:   if (last_bit) nxt = decode(byte_in, busy);
                F_ADDR:     if (last_bit) nxt = is_read ? F_RD_DATA : F_WR_DATA;
                F_WR_DATA:  if (last_bit) nxt = F_WR_END;
                F_WR_END,
                F_WREN_END: if (sck_rise) nxt = F_DISCARD;
                F_RD_DATA,
                F_SR_DATA,
                F_DISCARD:  nxt = state;
                default:    nxt = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            is_read  <= 1'b0;
            a8       <= 1'b0;
            ptr      <= '0;
            wr_data  <= '0;
            obuf     <= '0;
            so_data  <= 1'b0;
            so_oe    <= 1'b0;
            wren_req <= 1'b0;
            wr_req   <= 1'b0;
        end else begin
            wren_req <= cs_rise && (state == F_WREN_END);
            wr_req   <= cs_rise && (state == F_WR_END);
            if (!cs_act) begin
                cnt   <= '0;
                so_oe <= 1'b0;
            end else begin
                unique case (state)
                    F_OPCODE, F_ADDR, F_WR_DATA: begin
                        if (sck_rise) begin
                            shreg <= byte_in;
                            cnt   <= cnt + 3'd1;
                        end
                        if (last_bit && state == F_OPCODE) begin
                            is_read <= (byte_in[2:0] == OPC_RD_LOW);
                            a8      <= byte_in[3];
                        end
                        if (last_bit && state == F_ADDR)
                            ptr <= full_addr[ADDR_W-1:0];
                        if (last_bit && state == F_WR_DATA)
                            wr_data <= byte_in;
                    end
                    F_RD_DATA, F_SR_DATA: begin
                        if (sck_fall) begin
                            so_oe <= 1'b1;
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd0) begin
                                so_data <= fresh[7];
                                obuf    <= {fresh[6:0], 1'b0};
                            end else begin
                                so_data <= obuf[7];
                                obuf    <= {obuf[6:0], 1'b0};
                            end
                            if (state == F_RD_DATA && cnt == 3'd7)
                                ptr <= ptr + ONE_A;
                        end
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state == F_RD_DATA || state == F_SR_DATA)); // R11
    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_RD_DATA) |-> !busy); // R10

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int ADDR_W      = 9,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic [1:0] prot_level,
    output logic       so_data,
    output logic       so_oe
);
    logic              cs_act, cs_rise, sck_rise, sck_fall, mosi_s;
    logic              busy, wel, wren_req, wr_req;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rd_data, wr_data;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    eep_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .busy(busy), .wel(wel), .prot_level(prot_level), .rd_data(rd_data),
        .ptr(ptr), .wren_req(wren_req), .wr_req(wr_req), .wr_data(wr_data),
        .so_data(so_data), .so_oe(so_oe)
    );

    eep_store #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .wren_req(wren_req), .wr_req(wr_req),
        .wr_addr(ptr), .wr_data(wr_data), .prot_level(prot_level),
        .rd_addr(ptr), .rd_data(rd_data), .busy(busy), .wel(wel)
    );

endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
    localparam int HP  = 8;
    localparam int WRC = 1500;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic [1:0] bp_in = 2'd0;
    logic so_data, so_oe;
    logic mode3 = 1'b0;
    logic oe_seen;
    logic [7:0] shadow [512];
    logic [7:0] rb [16];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_eeprom_slave #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .prot_level(bp_in), .so_data(so_data), .so_oe(so_oe)
    );

    typedef struct packed {
        logic [8:0] addr;
        logic [7:0] data;
        logic [1:0] bp;
        logic       m3;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{9'h005, 8'hA5, 2'd0, 1'b0},
        '{9'h1FF, 8'h3C, 2'd0, 1'b1},
        '{9'h17F, 8'h11, 2'd1, 1'b0},
        '{9'h180, 8'h22, 2'd1, 1'b1},
        '{9'h0FF, 8'h33, 2'd2, 1'b0},
        '{9'h100, 8'h44, 2'd2, 1'b1},
        '{9'h000, 8'h55, 2'd3, 1'b0},
        '{9'h1C0, 8'h66, 2'd0, 1'b1}
    };

    function automatic logic blocked(input logic [1:0] lvl, input logic [8:0] a);
        case (lvl)
            2'd0: return 1'b0;
            2'd1: return a >= 9'h180;
            2'd2: return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cs_low();
        sck = mode3;
        wait_clk(HP);
        cs_n = 1'b0;
        oe_seen = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_high();
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(HP);
        end
        cs_n = 1'b1;
        wait_clk(2 * HP);
    endtask

    task automatic xfer_bit(input logic b, output logic s);
        sck = 1'b0;
        mosi = b;
        wait_clk(HP);
        s = so_data;
        if (so_oe) oe_seen = 1'b1;
        sck = 1'b1;
        wait_clk(HP);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(tx[i], s);
            rx[i] = s;
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic s;
        for (int i = n - 1; i >= 0; i--) xfer_bit(v[i], s);
    endtask

    task automatic do_wren();
        cs_low();
        send_bits(32'h06, 8);
        cs_high();
    endtask

    task automatic do_write(input logic [8:0] a, input logic [7:0] d);
        cs_low();
        send_bits({8'h0, 4'b0000, a[8], 3'b010, a[7:0], d}, 24);
        cs_high();
    endtask

    task automatic do_read(input logic [8:0] a, input int n);
        logic [7:0] r;
        cs_low();
        send_bits({16'h0, 4'b0000, a[8], 3'b011, a[7:0]}, 16);
        chk("R11 oe during opcode/address", {15'b0, oe_seen}, 16'd0);
        for (int k = 0; k < n; k++) begin
            xfer_byte(8'h00, r);
            rb[k] = r;
        end
        cs_high();
    endtask

    task automatic read_status(output logic [7:0] st);
        cs_low();
        send_bits(32'h05, 8);
        xfer_byte(8'h00, st);
        cs_high();
    endtask

    // Status polling across the end of a write cycle
    task automatic poll(input logic [7:0] first_exp, input logic [7:0] final_exp);
        logic [7:0] b;
        int k;
        cs_low();
        send_bits(32'h05, 8);
        xfer_byte(8'h00, b);
        chk("R4 first status byte", {8'h0, b}, {8'h0, first_exp});
        k = 0;
        while (b[0] && k < 40) begin
            xfer_byte(8'h00, b);
            if (b[0] && !b[1]) chk("R12 WEL lost while WIP set", {8'h0, b}, {8'h0, b | 8'h02});
            k++;
        end
        chk("R12 status after cycle", {8'h0, b}, {8'h0, final_exp});
        cs_high();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        logic [8:0] a;
        logic [7:0] sb;
        logic [7:0] fb;
        for (int i = 0; i < 512; i++) shadow[i] = 8'h00;
        wait_clk(5);
        chk("R1 oe in reset", {15'b0, so_oe}, 16'd0);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 oe after reset", {15'b0, so_oe}, 16'd0);
        read_status(st);
        chk("R1 status after reset", {8'h0, st}, 16'h0000);
        do_read(9'h010, 1);
        chk("R1 array cleared", {8'h0, rb[0]}, 16'h0000);

        // Vector table: enable, write, poll, read back
        foreach (VECS[v]) begin
            mode3 = VECS[v].m3;
            bp_in = VECS[v].bp;
            do_wren();
            read_status(st);
            chk("R5 WEL set by closed enable frame", {8'h0, st}, {8'h0, 4'b0, VECS[v].bp, 2'b10});
            do_write(VECS[v].addr, VECS[v].data);
            if (!blocked(VECS[v].bp, VECS[v].addr)) begin
                shadow[VECS[v].addr] = VECS[v].data;
                sb = {4'b0, VECS[v].bp, 2'b11};
                fb = {4'b0, VECS[v].bp, 2'b00};
            end else begin
                sb = {4'b0, VECS[v].bp, 2'b10};
                fb = sb;
            end
            poll(sb, fb);
            do_read(VECS[v].addr, 1);
            chk(blocked(VECS[v].bp, VECS[v].addr) ? "R9 protected byte kept" : "R6 R2 byte stored and read",
                {8'h0, rb[0]}, {8'h0, shadow[VECS[v].addr]});
            chk("R11 oe after cs high", {15'b0, so_oe}, 16'd0);
        end

        // Sequential read with wrap, mode 3
        bp_in = 2'd0;
        mode3 = 1'b1;
        do_read(9'h1FF, 7);
        for (int k = 0; k < 7; k++) begin
            a = 9'h1FF + 9'(k);
            chk("R3 sequential read wraps", {8'h0, rb[k]}, {8'h0, shadow[a]});
        end
        mode3 = 1'b0;

        // Enable and write inside one frame
        cs_low();
        send_bits(32'h06, 8);
        send_bits({8'h0, 8'h02, 8'h20, 8'h99}, 24);
        cs_high();
        read_status(st);
        chk("R7 same-frame enable gives no WEL", {8'h0, st}, 16'h0000);
        do_read(9'h020, 1);
        chk("R7 same-frame write not stored", {8'h0, rb[0]}, 16'h0000);

        // Write with latch clear
        do_write(9'h021, 8'h5A);
        read_status(st);
        chk("R7 write without WEL starts nothing", {8'h0, st}, 16'h0000);
        do_read(9'h021, 1);
        chk("R7 write without WEL not stored", {8'h0, rb[0]}, 16'h0000);

        // Enable frame with a ninth bit
        cs_low();
        send_bits({23'h0, 8'h06, 1'b0}, 9);
        cs_high();
        read_status(st);
        chk("R5 nine-bit enable frame ignored", {8'h0, st}, 16'h0000);

        // Wrong write frame lengths
        do_wren();
        cs_low();
        send_bits({8'h0, 8'h02, 8'h22, 8'hC3} >> 1, 23);
        cs_high();
        read_status(st);
        chk("R8 23-bit write starts nothing", {8'h0, st}, 16'h0002);
        cs_low();
        send_bits({7'h0, 8'h02, 8'h22, 8'hC3, 1'b1}, 25);
        cs_high();
        read_status(st);
        chk("R8 25-bit write starts nothing", {8'h0, st}, 16'h0002);
        do_read(9'h022, 1);
        chk("R8 byte unchanged", {8'h0, rb[0]}, 16'h0000);

        // Commands during a running write cycle
        do_write(9'h030, 8'h77);
        cs_low();
        send_bits({16'h0, 8'h03, 8'h30}, 16);
        xfer_byte(8'h00, st);
        cs_high();
        chk("R10 read ignored while busy", {15'b0, oe_seen}, 16'd0);
        do_write(9'h031, 8'h88);
        poll(8'h03, 8'h00);
        do_read(9'h030, 2);
        chk("R6 byte stored after busy test", {8'h0, rb[0]}, 16'h0077);
        chk("R10 write during busy not stored", {8'h0, rb[1]}, 16'h0000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule